// File: doc/BRIEF.md
# Embedded-Timing Video Stream Receiver

The receiver takes a byte stream of 8-bit or 10-bit digital component video in which line and field timing travels as embedded timing words. It finds each timing word, reads the field, vertical-blanking and line-half flags from it, and locks to the first start of field 1. After lock it forwards only the samples that the selected mode asks for. The three choices are the visible picture, the data carried on vertical-blanking lines, or the whole stream including the timing words themselves.

Forwarded samples leave on a valid/ready stream. Two marker bits travel with each sample. One flags the first forwarded sample of a line and the other flags the first forwarded sample of a frame. Samples pass through a short delay line so that a timing word can be recognised before its leading bytes would leave the block. The input handshake stalls only while the output holds a sample that has not yet been accepted.

Top module: `vid656_rx`

## Requirements
- R1: `wide_mode`=1 selects 10-bit input, and timing-word matching then uses bits 9:2, so any word from 0x3FC to 0x3FF counts as all-ones and any word from 0x000 to 0x003 counts as zero. `wide_mode`=0 matches on bits 7:0. Forwarded samples always carry the full input word unchanged.
- R2: A timing word is an all-ones byte, then two zero bytes, then a status byte. In the status byte, bit 6 is F (field), bit 5 is V (vertical blanking) and bit 4 is H (1 = end of active video, 0 = start of active video). A sequence that breaks this pattern carries no flags.
- R3: Before lock nothing is forwarded. Lock happens at the first status byte with F=0 that directly follows a status byte with F=1. `locked` then stays 1 until reset.
- R4: When `rx_mode`=2 (whole stream), every sample accepted after the locking status byte is forwarded, including all timing-word bytes.
- R5: When `rx_mode`=0 (picture), only the samples between a start-of-active-video word and the next end-of-active-video word, on lines with V=0, are forwarded. The four bytes of every timing word are removed.
- R6: In picture mode, each frame forwards only its first `active_lines` lines with V=0. A frame begins at each F 1-to-0 status change. `active_lines`=0 forwards nothing.
- R7: When `rx_mode`=1 (blanking data), only the samples between a start and the next end of active video, on lines with V=1, are forwarded. Timing-word bytes are excluded.
- R8: `out_sol` is 1 on the first forwarded sample after each start-of-active-video word, and 0 on every other forwarded sample.
- R9: `out_sof` is 1 on the first forwarded sample after each frame begins, and 0 on every other forwarded sample.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold. `in_ready` is low only in that state. A sample appears at the output once three later samples have been accepted.
- R11: During reset `out_valid`=0, `locked`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 10-bit samples, 0 = 8-bit in bits 7:0 |
| rx_mode | input | 2 | 0 picture, 1 blanking data, 2 whole stream |
| active_lines | input | LW | Picture lines forwarded per frame |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | DW | Input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Sink accepts output sample |
| out_data | output | DW | Forwarded sample |
| out_sol | output | 1 | First forwarded sample of a line |
| out_sof | output | 1 | First forwarded sample of a frame |
| locked | output | 1 | Field-1 synchronisation achieved |

## Verification
The assertions assume that `wide_mode`, `rx_mode` and `active_lines` change only while reset is held. They also assume that the sink may stall at any time, and that timing words never sit next to each other without the required prefix. The stimulus sets the configuration during reset and builds well-formed lines from timing words with correct protection bits, plus one broken prefix. Blanking and picture values never produce the all-ones/zero/zero prefix by accident, and random gaps on both handshakes test the stall behaviour.

// File: rtl/vid656_pkg.sv
// Shared types for the embedded-timing video receiver.
package vid656_pkg;

    // Length of the fixed prefix that comes before a status byte.
    localparam int PRE_LEN = 3;

    // Forwarding selection.
    typedef enum logic [1:0] {
        RX_ACTIVE = 2'd0,
        RX_VBI    = 2'd1,
        RX_FIELD  = 2'd2
    } rx_mode_e;

    // Per-sample bookkeeping carried through the delay line.
    typedef struct packed {
        logic vld;
        logic fwd;
        logic ctrl;
        logic sol;
        logic sof;
    } slot_tag_t;

endpackage

// File: rtl/vid656_match.sv
// Timing-word detector.
// Classifies each accepted sample as all-ones or zero and keeps a
// history of those classes, so it can flag a status byte that follows
// the all-ones/zero/zero prefix.
// Assumes: DW >= 10 when wide mode is used; din is stable while fire=1.
module vid656_match
    import vid656_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          wide,
    input  logic [DW-1:0] din,
    output logic          is_xy,
    output logic          xy_f,
    output logic          xy_v,
    output logic          xy_h
);

    localparam int TOPW = 8;

    logic [TOPW-1:0]    top_b;
    logic               cur_ones;
    logic               cur_zero;
    logic [PRE_LEN-1:0] h_ones;
    logic [PRE_LEN-1:0] h_zero;

    // Select the byte used for matching.
    always_comb begin
        top_b    = wide ? din[DW-1 -: TOPW] : din[TOPW-1:0];
        cur_ones = &top_b;
        cur_zero = ~|top_b;
    end

    // Shift the class history on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_ones <= '0;
            h_zero <= '0;
        end else if (fire) begin
            h_ones <= {h_ones[PRE_LEN-2:0], cur_ones};
            h_zero <= {h_zero[PRE_LEN-2:0], cur_zero};
        end
    end

    // Flag a status byte and pull out its flag bits.
    always_comb begin
        is_xy = fire && h_ones[PRE_LEN-1] && (&h_zero[PRE_LEN-2:0]);
        xy_f  = top_b[6];
        xy_v  = top_b[5];
        xy_h  = top_b[4];
    end

    // R2
    xy_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_xy |=> !is_xy);

endmodule

// File: rtl/vid656_timing.sv
// Field lock, line tracking and forwarding choice.
// Updates on status bytes: tracks F and V, whether the stream is inside
// a line's picture span, the picture-line count for the frame, and the
// pending line and frame markers. Gives the forward/marker tag for the
// sample being accepted, using the state before that sample updates it.
// Assumes: mode and limit are static outside reset.
module vid656_timing
    import vid656_pkg::*;
#(
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          is_xy,
    input  logic          xy_f,
    input  logic          xy_v,
    input  logic          xy_h,
    input  rx_mode_e      mode,
    input  logic [LW-1:0] limit,
    output logic          fwd_new,
    output logic          sol_new,
    output logic          sof_new,
    output logic          locked
);

    localparam logic [LW-1:0] CNT_MAX = '1;

    logic          f_q;
    logic          v_q;
    logic          in_line;
    logic          locked_q;
    logic [LW-1:0] line_cnt;
    logic          pend_sol;
    logic          pend_sof;
    logic          frame_start;

    // Decide whether the incoming sample belongs to the selected data.
    always_comb begin
        unique case (mode)
            RX_FIELD: fwd_new = locked_q;
            RX_VBI:   fwd_new = locked_q && in_line && v_q;
            default:  fwd_new = locked_q && in_line && !v_q && (line_cnt < limit);
        endcase
        sol_new     = fwd_new && pend_sol;
        sof_new     = fwd_new && pend_sof;
        frame_start = is_xy && f_q && !xy_f;
        locked      = locked_q;
    end

    // Update timing state from status bytes and consume markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q      <= 1'b0;
            v_q      <= 1'b0;
            in_line  <= 1'b0;
            locked_q <= 1'b0;
            line_cnt <= '0;
            pend_sol <= 1'b0;
            pend_sof <= 1'b0;
        end else if (fire) begin
            if (sol_new) pend_sol <= 1'b0;
            if (sof_new) pend_sof <= 1'b0;
            if (is_xy) begin
                f_q     <= xy_f;
                v_q     <= xy_v;
                in_line <= !xy_h;
                if (frame_start) begin
                    locked_q <= 1'b1;
                    pend_sof <= 1'b1;
                    line_cnt <= '0;
                end else if (xy_h && in_line && !v_q && locked_q && line_cnt != CNT_MAX) begin
                    line_cnt <= line_cnt + 1'b1;
                end
                if (!xy_h) pend_sol <= 1'b1;
            end
        end
    end

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);

endmodule

// File: rtl/vid656_delay.sv
// Sample delay line and output stage.
// Holds PRE_LEN+1 samples with their tags. When a status byte enters,
// the three prefix bytes already inside are marked as control, so they
// can be removed before they reach the last stage, which is the output.
// Assumes: field_mode is static outside reset.
module vid656_delay
    import vid656_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [DW-1:0] din,
    input  logic          new_fwd,
    input  logic          new_sol,
    input  logic          new_sof,
    input  logic          is_xy,
    input  logic          field_mode,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_sol,
    output logic          out_sof,
    output logic          in_ready
);

    localparam int STAGES = PRE_LEN + 1;
    localparam int LAST   = STAGES - 1;

    logic [DW-1:0] dat_q [STAGES];
    slot_tag_t     tag_q [STAGES];

    // Output view of the last stage.
    always_comb begin
        out_valid = tag_q[LAST].vld && tag_q[LAST].fwd && (field_mode || !tag_q[LAST].ctrl);
        out_data  = dat_q[LAST];
        out_sol   = tag_q[LAST].sol;
        out_sof   = tag_q[LAST].sof;
        in_ready  = !out_valid || out_ready;
    end

    // Shift on accept, mark prefix bytes, retire a consumed output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                dat_q[s] <= '0;
                tag_q[s] <= '0;
            end
        end else if (fire) begin
            dat_q[0] <= din;
            tag_q[0] <= '{vld: 1'b1, fwd: new_fwd, ctrl: is_xy, sol: new_sol, sof: new_sof};
            for (int s = 1; s < STAGES; s++) begin
                dat_q[s]      <= dat_q[s-1];
                tag_q[s]      <= tag_q[s-1];
                tag_q[s].ctrl <= tag_q[s-1].ctrl | is_xy;
            end
        end else if (out_valid && out_ready) begin
            tag_q[LAST].vld <= 1'b0;
        end
    end

    // R10
    out_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/vid656_rx.sv
// Embedded-timing video receiver top.
// Joins the timing-word detector, the lock/line state and the delay line.
// Assumes: configuration inputs change only during reset; in_data is
// 8-bit in bits 7:0 when wide_mode=0.
module vid656_rx
    import vid656_pkg::*;
#(
    parameter int DW = 10,
    parameter int LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_mode,
    input  logic [1:0]    rx_mode,
    input  logic [LW-1:0] active_lines,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_sol,
    output logic          out_sof,
    output logic          locked
);

    rx_mode_e mode;
    logic     fire;
    logic     is_xy;
    logic     xy_f;
    logic     xy_v;
    logic     xy_h;
    logic     fwd_new;
    logic     sol_new;
    logic     sof_new;

    // Decode mode and accept handshake.
    always_comb begin
        mode = rx_mode_e'(rx_mode);
        fire = in_valid && in_ready;
    end

    vid656_match #(.DW(DW)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .wide  (wide_mode),
        .din   (in_data),
        .is_xy (is_xy),
        .xy_f  (xy_f),
        .xy_v  (xy_v),
        .xy_h  (xy_h)
    );

    vid656_timing #(.LW(LW)) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .is_xy   (is_xy),
        .xy_f    (xy_f),
        .xy_v    (xy_v),
        .xy_h    (xy_h),
        .mode    (mode),
        .limit   (active_lines),
        .fwd_new (fwd_new),
        .sol_new (sol_new),
        .sof_new (sof_new),
        .locked  (locked)
    );

    vid656_delay #(.DW(DW)) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .din        (in_data),
        .new_fwd    (fwd_new),
        .new_sol    (sol_new),
        .new_sof    (sof_new),
        .is_xy      (is_xy),
        .field_mode (mode == RX_FIELD),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sol    (out_sol),
        .out_sof    (out_sof),
        .in_ready   (in_ready)
    );

    // R3
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> locked);

    // R9
    sof_has_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sof && (rx_mode == 2'd0) |-> out_sol);

endmodule

// File: tb/vid656_rx_tb.sv
`timescale 1ns/1ps
module vid656_rx_tb;

    localparam int DW = 10;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide_mode = 1'b0;
    logic [1:0]    rx_mode = 2'd0;
    logic [LW-1:0] active_lines = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_sol;
    logic          out_sof;
    logic          locked;

    always #4 clk = ~clk;

    vid656_rx #(.DW(DW), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .rx_mode(rx_mode),
        .active_lines(active_lines), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof), .locked(locked)
    );

    int checks = 0;
    int errors = 0;
    int stim[$];
    int exp_d[$];
    bit exp_sol[$];
    bit exp_sof[$];
    int ones_alt = 0;
    int line_no = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic int enc(input int b, input bit wide, input int low);
        return wide ? ((b << 2) | (low & 3)) : b;
    endfunction

    function automatic int status_byte(input int f, input int v, input int h);
        return 128 | (f << 6) | (v << 5) | (h << 4) | ((v ^ h) << 3) |
               ((f ^ h) << 2) | ((f ^ v) << 1) | (f ^ v ^ h);
    endfunction

    function automatic int top_of(input int w, input bit wide);
        return wide ? ((w >> 2) & 255) : (w & 255);
    endfunction

    // R1, R2: timing word with varying all-ones and zero encodings
    task automatic add_word(input bit wide, input int f, input int v, input int h);
        ones_alt++;
        stim.push_back(wide ? ((ones_alt % 2) ? 'h3FC : 'h3FF) : 'hFF);
        stim.push_back(wide ? 'h002 : 0);
        stim.push_back(0);
        stim.push_back(enc(status_byte(f, v, h), wide, 0));
    endtask

    task automatic add_line(input bit wide, input int f, input int v);
        int base;
        base = 'h20 + 8 * line_no;
        line_no++;
        add_word(wide, f, v, 1);
        for (int k = 0; k < 6; k++) stim.push_back(enc((k % 2) ? 'h10 : 'h80, wide, 0));
        add_word(wide, f, v, 0);
        for (int k = 0; k < 8; k++) stim.push_back(enc(base + k, wide, k));
    endtask

    task automatic build(input bit wide);
        stim.delete();
        line_no = 0;
        // R2: broken prefix followed by an F=1 status, must not count
        stim.push_back(wide ? 'h3FF : 'hFF);
        stim.push_back(0);
        stim.push_back(enc(1, wide, 0));
        stim.push_back(enc(status_byte(1, 1, 1), wide, 0));
        repeat (2) add_line(wide, 0, 1);   // no F=1 seen yet: no lock
        repeat (2) add_line(wide, 1, 1);
        repeat (2) add_line(wide, 0, 1);   // lock here
        repeat (3) add_line(wide, 0, 0);
        repeat (1) add_line(wide, 1, 1);
        repeat (2) add_line(wide, 1, 0);
        repeat (1) add_line(wide, 0, 1);   // second frame
        repeat (2) add_line(wide, 0, 0);
        repeat (1) add_line(wide, 1, 1);
    endtask

    // Behavioural reference for the forwarded sequence
    task automatic model(input bit wide, input int mode, input int lines);
        int n;
        bit xy[$];
        bit fe[$];
        bit so[$];
        bit sf[$];
        int fq, vq, inl, lk, lc, ps, pf;
        n = stim.size();
        exp_d.delete(); exp_sol.delete(); exp_sof.delete();
        fq = 0; vq = 0; inl = 0; lk = 0; lc = 0; ps = 0; pf = 0;
        for (int i = 0; i < n; i++) begin
            bit x;
            bit e;
            int b;
            b = top_of(stim[i], wide);
            x = (i >= 3) && (top_of(stim[i-3], wide) == 255) &&
                (top_of(stim[i-2], wide) == 0) && (top_of(stim[i-1], wide) == 0);
            if (mode == 2)      e = lk != 0;
            else if (mode == 1) e = (lk != 0) && (inl != 0) && (vq != 0);
            else                e = (lk != 0) && (inl != 0) && (vq == 0) && (lc < lines);
            xy.push_back(x); fe.push_back(e);
            so.push_back(e && ps != 0); sf.push_back(e && pf != 0);
            if (e) begin ps = 0; pf = 0; end
            if (x) begin
                int fb, vb, hb;
                fb = (b >> 6) & 1; vb = (b >> 5) & 1; hb = (b >> 4) & 1;
                if (fq == 1 && fb == 0) begin lk = 1; pf = 1; lc = 0; end
                else if (hb == 1 && inl == 1 && vq == 0 && lk == 1) lc++;
                if (hb == 0) ps = 1;
                fq = fb; vq = vb; inl = 1 - hb;
            end
        end
        for (int i = 0; i <= n - 4; i++) begin
            bit ctl;
            ctl = xy[i] || xy[i+1] || xy[i+2] || xy[i+3];
            if (fe[i] && (mode == 2 || !ctl)) begin
                exp_d.push_back(stim[i]);
                exp_sol.push_back(so[i]);
                exp_sof.push_back(sf[i]);
            end
        end
    endtask

    task automatic run(input string req, input bit wide, input int mode, input int lines, input int stall);
        int idx;
        int cyc;
        int tail;
        bit held;
        logic [DW-1:0] held_d;
        build(wide);
        model(wide, mode, lines);
        @(negedge clk);
        rst_n = 1'b0; wide_mode = wide; rx_mode = 2'(mode); active_lines = LW'(lines);
        in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        // R11
        chk(out_valid == 1'b0 && locked == 1'b0 && in_ready == 1'b1, "R11", "reset state",
            {out_valid, locked, in_ready}, 3'b001);
        rst_n = 1'b1;
        idx = 0; cyc = 0; tail = 0; held = 0; held_d = '0;
        while (tail < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc > 20000) begin
                chk(1'b0, req, "run watchdog", cyc, 20000);
                break;
            end
            if (held) chk(out_valid && out_data == held_d, "R10", "stalled output hold", int'(out_data), int'(held_d));
            out_ready = ($urandom_range(0, 99) >= stall);
            in_valid  = (idx < stim.size()) && ($urandom_range(0, 99) >= stall / 2);
            in_data   = (idx < stim.size()) ? DW'(stim[idx]) : '0;
            #1;
            held = out_valid && !out_ready;
            held_d = out_data;
            if (out_valid && out_ready) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, req, "unexpected output (R3 lock/filter)", int'(out_data), -1);
                end else begin
                    chk(out_data == DW'(exp_d[0]), req, "data", int'(out_data), exp_d[0]);
                    chk(out_sol == exp_sol[0], "R8", "line marker", out_sol, exp_sol[0]);
                    chk(out_sof == exp_sof[0], "R9", "frame marker", out_sof, exp_sof[0]);
                    void'(exp_d.pop_front()); void'(exp_sol.pop_front()); void'(exp_sof.pop_front());
                end
            end
            if (in_valid && in_ready) idx++;
            if (idx >= stim.size()) tail++;
        end
        in_valid = 1'b0;
        chk(exp_d.size() == 0, req, "samples still owed", exp_d.size(), 0);
        // R3
        chk(locked == 1'b1, "R3", "lock after field-1 start", locked, 1);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run("R5", 1'b0, 0, 4, 30);     // picture, limit cuts the fifth line (R6)
        run("R6", 1'b0, 0, 0, 10);     // limit zero: nothing forwarded
        run("R7", 1'b0, 1, 4, 30);     // blanking-line data only
        run("R4", 1'b0, 2, 4, 30);     // whole stream after lock
        run("R1", 1'b1, 0, 100, 20);   // 10-bit picture
        run("R1", 1'b1, 2, 4, 60);     // 10-bit whole stream, heavy stalls
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule